// File: doc/BRIEF.md
# Program Counter Sequencer with Branch and Jump Targets

This block holds the program counter of a processor that fetches fixed 32-bit instructions. Each cycle it works out the address of the next instruction from the current one. The decode stage tells it which kind of control flow the current instruction has. The block then does one of four things:

- step to the following word;
- take a short relative branch, which is conditional on two register operands being equal or unequal;
- splice a long word target under the top bits of the incremented address;
- go to an address held in a register.

The chosen address is registered on each clock edge where the stall input is low. The block also reports when the transfer is not sequential. For calls it supplies the return address.

A register-sourced target whose two low bits are not zero is forced onto a word boundary. A sticky flag records that this happened, and only reset clears it. Fetch, decode and the register file sit outside this block.

Top module: `pc_step_unit`

## Requirements
- R1: While reset is asserted and after its release, `pc` is 0 and `jr_misaligned` is 0 until the first clock edge with reset released.
- R2: Class code 0 (sequential): `next_pc` = `pc`+4 and `taken` is 0.
- R3: Class code 1 (branch if equal): if `opnd_a` == `opnd_b`, `next_pc` = `pc`+4+(sign-extended `imm16` × 4) and `taken` is 1; otherwise `next_pc` = `pc`+4 and `taken` is 0.
- R4: Class code 2 (branch if not equal): taken exactly when `opnd_a` != `opnd_b`, with the same target and fall-through addresses as R3.
- R5: Class code 3 (jump): `next_pc` = {(`pc`+4)[31:28], `jump_tgt`[25:0], 2'b00} and `taken` is 1.
- R6: Class code 4 (jump and link): `next_pc` is formed as in R5, `taken` is 1, and `link_addr` = `pc`+4; for every other class `link_addr` is 0.
- R7: Class code 5 (jump to register): `next_pc` = {`jr_value`[31:2], 2'b00} and `taken` is 1.
- R8: A class-5 cycle with `stall` low and `jr_value`[1:0] != 0 sets `jr_misaligned` at that clock edge. The flag stays at 1 until reset. A stalled class-5 cycle does not set it.
- R9: Class codes 6 and 7 behave exactly like code 0.
- R10: At a clock edge with `stall` high, `pc` keeps its value. At a clock edge with `stall` low, `pc` takes the `next_pc` value that was presented before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Hold the PC at this edge |
| ctrl_class | input | 3 | Control-flow class of the current instruction |
| imm16 | input | 16 | Branch word offset, signed |
| jump_tgt | input | 26 | Word target of a jump |
| opnd_a | input | 32 | First compared register operand |
| opnd_b | input | 32 | Second compared register operand |
| jr_value | input | 32 | Register-supplied target address |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address that will be loaded at the next unstalled edge |
| taken | output | 1 | Non-sequential transfer selected |
| link_addr | output | 32 | Return address for jump and link, else 0 |
| jr_misaligned | output | 1 | Sticky flag for an unaligned register target |

## Verification
The PC is the only state that moves, so a corrupted PC shows at once in `pc` and in every address derived from it, one clock after the edge that loaded it. A bad select or a wrong offset scaling shows in `next_pc` in the same cycle, before any edge. A sticky flag that was lost or set spuriously becomes visible at the edge that follows the register-jump. Sweeps over every class code, over boundary offsets and over both compare outcomes catch these faults within one or two cycles. A jump placed across a 256 MiB boundary exposes a top nibble taken from the wrong address.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [2:0] {
        CF_SEQ  = 3'd0,
        CF_BEQ  = 3'd1,
        CF_BNE  = 3'd2,
        CF_JMP  = 3'd3,
        CF_JAL  = 3'd4,
        CF_JREG = 3'd5
    } cflow_e;

    localparam int unsigned CLASS_W    = 3;
    localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/pcu_compare.sv
module pcu_compare
    import pcu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CLASS_W-1:0]  ctrl_class,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    output logic                br_take
);

    logic same;

    always_comb begin
        same    = (opnd_a == opnd_b);
        br_take = 1'b0;
        case (ctrl_class)
            CF_BEQ:  br_take = same;
            CF_BNE:  br_take = !same;
            default: br_take = 1'b0;
        endcase
    end

    // R3/R4: a branch decision needs a branch class and the right compare outcome
    a_r3_take_needs_branch: assert property (@(posedge clk) disable iff (!rst_n)
        br_take |-> ((ctrl_class == CF_BEQ && opnd_a == opnd_b) ||
                     (ctrl_class == CF_BNE && opnd_a != opnd_b)));

endmodule

// File: rtl/pcu_addr_gen.sv
module pcu_addr_gen
    import pcu_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 16,
    parameter int unsigned TGT_W  = 26
) (
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [IMM_W-1:0]  imm,
    input  logic [TGT_W-1:0]  tgt,
    input  logic [ADDR_W-1:0] jr_raw,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] br_addr,
    output logic [ADDR_W-1:0] jmp_addr,
    output logic [ADDR_W-1:0] jr_addr,
    output logic              jr_bad
);

    localparam int unsigned EXT_W = ADDR_W - IMM_W - WORD_SHIFT;
    localparam int unsigned HI_W  = ADDR_W - TGT_W - WORD_SHIFT;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << WORD_SHIFT);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        seq_addr = pc_cur + STEP;
        offset   = {{EXT_W{imm[IMM_W-1]}}, imm, {WORD_SHIFT{1'b0}}};
        br_addr  = seq_addr + offset;
        jmp_addr = {seq_addr[ADDR_W-1 -: HI_W], tgt, {WORD_SHIFT{1'b0}}};
        jr_addr  = {jr_raw[ADDR_W-1:WORD_SHIFT], {WORD_SHIFT{1'b0}}};
        jr_bad   = |jr_raw[WORD_SHIFT-1:0];
    end

endmodule

// File: rtl/pc_step_unit.sv
module pc_step_unit
    import pcu_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned IMM_W      = 16,
    parameter int unsigned TGT_W      = 26,
    parameter logic [31:0] RESET_ADDR = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic [2:0]        ctrl_class,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [TGT_W-1:0]  jump_tgt,
    input  logic [ADDR_W-1:0] opnd_a,
    input  logic [ADDR_W-1:0] opnd_b,
    input  logic [ADDR_W-1:0] jr_value,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] next_pc,
    output logic              taken,
    output logic [ADDR_W-1:0] link_addr,
    output logic              jr_misaligned
);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              misal;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic [ADDR_W-1:0] seq_addr, br_addr, jmp_addr, jr_addr;
    logic              jr_bad, br_take;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_taken;
    logic [ADDR_W-1:0] sel_link;

    pcu_compare #(.DATA_W(ADDR_W)) cmp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_class (ctrl_class),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .br_take    (br_take)
    );

    pcu_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .TGT_W(TGT_W)) agen_i (
        .pc_cur   (state_q.pc),
        .imm      (imm16),
        .tgt      (jump_tgt),
        .jr_raw   (jr_value),
        .seq_addr (seq_addr),
        .br_addr  (br_addr),
        .jmp_addr (jmp_addr),
        .jr_addr  (jr_addr),
        .jr_bad   (jr_bad)
    );

    always_comb begin
        sel_addr  = seq_addr;
        sel_taken = 1'b0;
        sel_link  = '0;
        case (ctrl_class)
            CF_BEQ, CF_BNE: begin
                sel_taken = br_take;
                sel_addr  = br_take ? br_addr : seq_addr;
            end
            CF_JMP: begin
                sel_taken = 1'b1;
                sel_addr  = jmp_addr;
            end
            CF_JAL: begin
                sel_taken = 1'b1;
                sel_addr  = jmp_addr;
                sel_link  = seq_addr;
            end
            CF_JREG: begin
                sel_taken = 1'b1;
                sel_addr  = jr_addr;
            end
            default: begin
                sel_taken = 1'b0;
                sel_addr  = seq_addr;
            end
        endcase

        state_d = state_q;
        if (!stall) begin
            state_d.pc = sel_addr;
            if (ctrl_class == CF_JREG && jr_bad) begin
                state_d.misal = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{pc: RESET_ADDR[ADDR_W-1:0], misal: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign pc            = state_q.pc;
    assign next_pc       = sel_addr;
    assign taken         = sel_taken;
    assign link_addr     = sel_link;
    assign jr_misaligned = state_q.misal;

    // R10: stalled edge keeps the PC
    a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(stall) |-> $stable(pc));

    // R10: unstalled edge loads the presented next address
    a_r10_loads_next: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> pc == $past(next_pc));

    // R8: misalignment flag is sticky
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        jr_misaligned |=> jr_misaligned);

    // R7: PC remains word aligned
    a_r7_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00);

    // R6: a return address is only offered on a transfer
    a_r6_link_only_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (link_addr != '0) |-> taken);

endmodule

// File: tb/pc_step_unit_tb_top.sv
module pc_step_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stall;
    logic [2:0]  ctrl_class;
    logic [15:0] imm16;
    logic [25:0] jump_tgt;
    logic [31:0] opnd_a, opnd_b, jr_value;
    logic [31:0] pc, next_pc, link_addr;
    logic        taken, jr_misaligned;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_pc;
    logic        m_mis;

    always #10 clk = ~clk;

    pc_step_unit dut_i (
        .clk(clk), .rst_n(rst_n), .stall(stall), .ctrl_class(ctrl_class),
        .imm16(imm16), .jump_tgt(jump_tgt), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .jr_value(jr_value), .pc(pc), .next_pc(next_pc), .taken(taken),
        .link_addr(link_addr), .jr_misaligned(jr_misaligned)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R9";
        endcase
    endfunction

    // apply one cycle of stimulus; called just after a negedge
    task automatic step(input logic [2:0] c, input logic [15:0] im, input logic [25:0] tg,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] jv,
                        input logic st);
        logic [31:0] seq, exp_n, exp_l;
        logic        exp_t;
        ctrl_class = c; imm16 = im; jump_tgt = tg;
        opnd_a = a; opnd_b = b; jr_value = jv; stall = st;
        #2;
        seq   = m_pc + 32'd4;
        exp_n = seq; exp_t = 1'b0; exp_l = 32'd0;
        if ((c == 3'd1 && a == b) || (c == 3'd2 && a != b)) begin
            exp_t = 1'b1;
            exp_n = seq + {{14{im[15]}}, im, 2'b00};
        end else if (c == 3'd3 || c == 3'd4) begin
            exp_t = 1'b1;
            exp_n = {seq[31:28], tg, 2'b00};
            if (c == 3'd4) exp_l = seq;
        end else if (c == 3'd5) begin
            exp_t = 1'b1;
            exp_n = {jv[31:2], 2'b00};
        end
        chk({req_of(c), " next_pc"}, next_pc, exp_n);
        chk({req_of(c), " taken"}, {31'd0, taken}, {31'd0, exp_t});
        chk("R6 link_addr", link_addr, exp_l);
        @(negedge clk);
        if (!st) begin
            m_pc = exp_n;
            if (c == 3'd5 && jv[1:0] != 2'b00) m_mis = 1'b1;
        end
        chk("R10 pc after edge", pc, m_pc);
        chk("R8 misaligned flag", {31'd0, jr_misaligned}, {31'd0, m_mis});
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] imm_set [5];
        imm_set = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000};
        rst_n = 1'b0; stall = 1'b0; ctrl_class = 3'd0; imm16 = '0; jump_tgt = '0;
        opnd_a = '0; opnd_b = '0; jr_value = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset pc", pc, 32'd0);
        chk("R1 reset flag", {31'd0, jr_misaligned}, 32'd0);
        m_pc = 32'd0; m_mis = 1'b0;
        rst_n = 1'b1;
        chk("R1 pc after release", pc, 32'd0);

        // sweep: all class codes x boundary offsets x compare outcomes
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 5; k++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [31:0] a = 32'h1357_0000 + 32'(k * 977);
                    logic [31:0] b = (e == 1) ? a : (a ^ (32'h1 << (k * 7)));
                    logic [25:0] tg = 26'(32'h0155_5555 * (k + 1) + c);
                    logic [31:0] jv = 32'h4000_0000 + 32'(k * 64) + ((c == 5 && e == 0) ? 32'd0 : 32'd0);
                    step(3'(c), imm_set[k], tg, a, b, jv, 1'b0);
                end
            end
        end

        // stall holds PC for several classes, including unaligned jr (no flag)
        step(3'd3, 16'h0, 26'h00_ABCD, 32'd1, 32'd2, 32'h0, 1'b1);
        step(3'd1, 16'h0010, 26'h0, 32'd5, 32'd5, 32'h0, 1'b1);
        step(3'd5, 16'h0, 26'h0, 32'd0, 32'd0, 32'h2000_0003, 1'b1);

        // jump across a 256 MiB boundary: top bits from pc+4
        step(3'd5, 16'h0, 26'h0, 32'd0, 32'd0, 32'h0FFF_FFFC, 1'b0);
        step(3'd3, 16'h0, 26'h000_0010, 32'd0, 32'd0, 32'h0, 1'b0);
        step(3'd5, 16'h0, 26'h0, 32'd0, 32'd0, 32'h0FFF_FFFC, 1'b0);
        step(3'd4, 16'h0, 26'h3FF_FFFF, 32'd0, 32'd0, 32'h0, 1'b0);

        // unaligned register targets: each low-bit pattern, flag sticks
        for (int lb = 1; lb < 4; lb++) begin
            step(3'd5, 16'h0, 26'h0, 32'd0, 32'd0, 32'h0000_8000 + 32'(lb), 1'b0);
            step(3'd0, 16'h0, 26'h0, 32'd0, 32'd0, 32'h0, 1'b0);
        end
        step(3'd5, 16'h0, 26'h0, 32'd0, 32'd0, 32'h0000_0100, 1'b0);

        // reset clears the sticky flag and the PC
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 re-reset pc", pc, 32'd0);
        chk("R8 flag cleared by reset", {31'd0, jr_misaligned}, 32'd0);
        rst_n = 1'b1;
        m_pc = 32'd0; m_mis = 1'b0;
        step(3'd6, 16'h0, 26'h0, 32'd0, 32'd0, 32'h0, 1'b0);
        step(3'd7, 16'hFFFF, 26'h1, 32'd3, 32'd3, 32'h3, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule